// File: doc/BRIEF.md
# DRAM Strobe-Sequence Mode Decoder

This block watches the control strobes of an asynchronous page-mode DRAM: the row strobe, an upper and a lower byte column strobe, write enable and output enable. It samples them as plain levels on a fast system clock. From the order in which the strobes change, it sorts each memory cycle into one of a fixed set of kinds: read, early write, delayed write, read-modify-write, refresh with the row address only, refresh with the column strobe set up before the row strobe, self refresh, and the page-mode version of each access kind. It can act as the front end of a behavioural memory model or as a protocol checker next to a memory controller.

The two byte strobes are merged into one column strobe. The first of them to fall opens a column access, and the access closes only when both are high again. Write data and output drive stay separate for each byte lane. The block also keeps the row counter that the internal refresh uses. It flags any cycle in which the two byte lanes try to perform different kinds of access.

Top module: `strobe_mode_decoder`

## Requirements
- R1: One clock after reset, cyc_pulse, byte_wr, byte_drive and mix_err are 0, and cyc_mode, row_q, col_q and ref_row are 0.
- R2: A column access opens on a sample where ras_n is low and at least one byte strobe is low after both were high. It closes on the first later sample where both byte strobes are high, or where ras_n is high. cyc_pulse is 1 during exactly the one clock that follows the closing sample, and cyc_mode carries the cycle code in that clock. Codes: 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 strobe-first refresh, 7 self refresh, 9 to 12 the page versions of codes 1 to 4.
- R3: If ras_n falls while either byte strobe is already low, the cycle is a strobe-first refresh. Code 6 is pulsed in the clock after the sample where ras_n is high again, and ref_row steps by one in that same clock. byte_wr stays 0 for the whole cycle, whatever the level of we_n.
- R4: If ras_n stays low for more than SELF_CYC samples during a strobe-first refresh, code 7 is reported instead of code 6, and ref_row keeps its value.
- R5: ras_n going low and high again with no byte strobe falling in between gives code 5 in the clock after the rising sample. ref_row is unchanged. row_q takes the value of addr at the sample where ras_n falls, for every cycle that is not a strobe-first refresh.
- R6: An access that opens with we_n low is an early write (2). An access that opens with we_n high and sees we_n fall before it closes is a read-modify-write (4) if oe_n was low on an earlier sample of that access, and a delayed write (3) otherwise. Any other access is a read (1).
- R7: byte_wr bit 0 is the lower lane (lcas_n) and bit 1 is the upper lane (ucas_n). A lane's bit pulses for one clock after a sample in which its strobe falls while we_n is low. It also pulses after a sample in which we_n falls while that strobe is low, in an access that opened with we_n high and has not yet written. It is never 1 after a sample with ras_n high.
- R8: byte_drive[i] is 1 in the clock after a sample in which ras_n, strobe i and oe_n are low and we_n is high, inside an access that opened with we_n high and has not written. Otherwise it is 0. Bit order is the same as byte_wr.
- R9: The second and later accesses within one low period of ras_n report their code plus 8. col_q takes the value of addr at the opening sample of each access.
- R10: mix_err pulses in the clock after a sample in which a byte strobe falls inside an access that is already open, if we_n differs from its level at the opening sample or if a delayed write has already taken place in that access.
- R11: ref_row is 9 bits wide and wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe level, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write enable level, active low |
| oe_n | input | 1 | Output enable level, active low |
| addr | input | 9 | Multiplexed row/column address |
| cyc_pulse | output | 1 | One-clock marker of a decoded cycle |
| cyc_mode | output | 4 | Code of the last decoded cycle |
| byte_wr | output | 2 | Per-lane write strobe, bit 1 upper |
| byte_drive | output | 2 | Per-lane output drive, bit 1 upper |
| row_q | output | 9 | Latched row address |
| col_q | output | 9 | Latched column address |
| ref_row | output | 9 | Internal refresh row counter |
| mix_err | output | 1 | Lane mixing violation pulse |

## Verification
The hardest states to reach from the ports are the lane-mixing faults and the counter wrap. A mixing fault needs one byte strobe to fall while the other lane already holds an open access, with write enable changed or a delayed write already done. The wrap needs 512 refresh cycles in a row. Directed sequences stagger the two byte strobes around a write-enable edge in both orders, and a dedicated loop runs short refresh cycles until the counter reaches 511 and then issues one more. Around these sequences, seeded random cycles of every kind use random lane masks, page counts, addresses and row-strobe hold times, some of them beyond the self-refresh threshold.

// File: rtl/strobe_dec_pkg.sv
`timescale 1ns/1ps
package strobe_dec_pkg;

    localparam int LANES = 2;

    // cycle codes reported on cyc_mode
    localparam logic [3:0] MD_NONE     = 4'd0;
    localparam logic [3:0] MD_READ     = 4'd1;
    localparam logic [3:0] MD_EARLY_WR = 4'd2;
    localparam logic [3:0] MD_LATE_WR  = 4'd3;
    localparam logic [3:0] MD_RMW      = 4'd4;
    localparam logic [3:0] MD_ROW_REF  = 4'd5;
    localparam logic [3:0] MD_CBR_REF  = 4'd6;
    localparam logic [3:0] MD_SELF_REF = 4'd7;

    typedef enum logic [1:0] {
        PH_IDLE, // row strobe high
        PH_ROW,  // row open, no column access in progress
        PH_COL,  // column access open
        PH_CBR   // strobe-first refresh in progress
    } phase_e;

    // sampled pin levels (active low as seen on the wires)
    typedef struct packed {
        logic             ras;
        logic [LANES-1:0] cas;
        logic             we;
        logic             oe;
    } pins_t;

    typedef struct packed {
        logic             ras_fall;
        logic             ras_rise;
        logic [LANES-1:0] cas_fall;
        logic             any_fall;
        logic             all_rise;
        logic             we_fall;
    } edges_t;

    function automatic logic [3:0] access_code(input logic early, input logic wrote,
                                               input logic rd_seen, input logic page);
        logic [3:0] base;
        if (early)       base = MD_EARLY_WR;
        else if (wrote)  base = rd_seen ? MD_RMW : MD_LATE_WR;
        else             base = MD_READ;
        return {page, base[2:0]};
    endfunction

endpackage

// File: rtl/strobe_sampler.sv
`timescale 1ns/1ps
module strobe_sampler
    import strobe_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    output edges_t           ev
);
    logic             p_ras;
    logic             p_we;
    logic [LANES-1:0] p_cas;
    logic [LANES-1:0] fall_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_ras <= 1'b1;
            p_we  <= 1'b1;
            p_cas <= '1;
        end else begin
            p_ras <= ras_n;
            p_we  <= we_n;
            p_cas <= cas_n;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign fall_v[i] = p_cas[i] & ~cas_n[i];
    end

    always_comb begin
        ev.ras_fall = p_ras & ~ras_n;
        ev.ras_rise = ~p_ras & ras_n;
        ev.cas_fall = fall_v;
        ev.any_fall = (&p_cas) & ~(&cas_n);
        ev.all_rise = ~(&p_cas) & (&cas_n);
        ev.we_fall  = p_we & ~we_n;
    end

endmodule

// File: rtl/refresh_row_ctr.sv
`timescale 1ns/1ps
module refresh_row_ctr #(
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [RW-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)       row <= '0;
        else if (step) row <= row + 1'b1;
    end

    // R11
    ref_step_chk: assert property (@(posedge clk) disable iff (rst)
        (row != $past(row)) |-> (row == $past(row) + 1'b1));

endmodule

// File: rtl/cycle_classifier.sv
`timescale 1ns/1ps
module cycle_classifier
    import strobe_dec_pkg::*;
#(
    parameter int AW       = 9,
    parameter int SELF_CYC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  pins_t            cur,
    input  edges_t           ev,
    input  logic [AW-1:0]    addr,
    output logic             emit_q,
    output logic [3:0]       code_q,
    output logic [LANES-1:0] wr_q,
    output logic [LANES-1:0] drv_q,
    output logic             mix_q,
    output logic [AW-1:0]    row_q,
    output logic [AW-1:0]    col_q,
    output logic             cbr_step
);
    localparam int              CNT_W    = $clog2(SELF_CYC + 1);
    localparam logic [CNT_W-1:0] SELF_LIM = CNT_W'(SELF_CYC);

    phase_e           st;
    logic             had_col, early, wrote, rd_seen, open_we;
    logic [CNT_W-1:0] cbr_cnt;

    logic             emit_n, mix_n, acc_rd, wrote_eff;
    logic [3:0]       code_n;
    logic [LANES-1:0] wr_n, drv_n, cas_low;

    always_comb begin
        cas_low   = ~cur.cas;
        emit_n    = 1'b0;
        code_n    = MD_NONE;
        wr_n      = '0;
        mix_n     = 1'b0;
        cbr_step  = 1'b0;
        acc_rd    = 1'b0;
        wrote_eff = wrote | (ev.we_fall & ~early);
        unique case (st)
            PH_ROW: begin
                if (!cur.ras) begin
                    wr_n   = ev.cas_fall & {LANES{~cur.we}};
                    acc_rd = ev.any_fall;
                end else if (!had_col) begin
                    emit_n = 1'b1;
                    code_n = MD_ROW_REF;
                end
            end
            PH_COL: begin
                if (!cur.ras) begin
                    wr_n = ev.cas_fall & {LANES{~cur.we}};
                    if (ev.we_fall && !early && !wrote)
                        wr_n = wr_n | cas_low;
                    mix_n  = (|ev.cas_fall) && ((cur.we != open_we) || wrote);
                    acc_rd = !early && !wrote;
                end
                if (ev.all_rise || ev.ras_rise) begin
                    emit_n = 1'b1;
                    code_n = access_code(early, wrote_eff, rd_seen, had_col);
                end
            end
            PH_CBR: begin
                if (ev.ras_rise) begin
                    emit_n   = 1'b1;
                    cbr_step = (cbr_cnt < SELF_LIM);
                    code_n   = cbr_step ? MD_CBR_REF : MD_SELF_REF;
                end
            end
            default: ;
        endcase
        drv_n = (cur.ras || !acc_rd) ? '0 : (cas_low & {LANES{~cur.oe & cur.we}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PH_IDLE;
            had_col <= 1'b0;
            early   <= 1'b0;
            wrote   <= 1'b0;
            rd_seen <= 1'b0;
            open_we <= 1'b1;
            cbr_cnt <= '0;
            emit_q  <= 1'b0;
            code_q  <= MD_NONE;
            wr_q    <= '0;
            drv_q   <= '0;
            mix_q   <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            emit_q <= emit_n;
            if (emit_n) code_q <= code_n;
            wr_q   <= wr_n;
            drv_q  <= drv_n;
            mix_q  <= mix_n;
            unique case (st)
                PH_IDLE: begin
                    if (ev.ras_fall) begin
                        if (!(&cur.cas)) begin
                            st      <= PH_CBR;
                            cbr_cnt <= '0;
                        end else begin
                            st      <= PH_ROW;
                            had_col <= 1'b0;
                            row_q   <= addr;
                        end
                    end
                end
                PH_ROW: begin
                    if (cur.ras) begin
                        st <= PH_IDLE;
                    end else if (ev.any_fall) begin
                        st      <= PH_COL;
                        col_q   <= addr;
                        early   <= ~cur.we;
                        open_we <= cur.we;
                        wrote   <= 1'b0;
                        rd_seen <= 1'b0;
                    end
                end
                PH_COL: begin
                    if (cur.ras) begin
                        st <= PH_IDLE;
                    end else begin
                        if (ev.all_rise) begin
                            st      <= PH_ROW;
                            had_col <= 1'b1;
                        end
                        if (ev.we_fall && !early) wrote <= 1'b1;
                        if (!cur.oe && cur.we && !early && !wrote) rd_seen <= 1'b1;
                    end
                end
                PH_CBR: begin
                    if (cur.ras)                st      <= PH_IDLE;
                    else if (cbr_cnt < SELF_LIM) cbr_cnt <= cbr_cnt + 1'b1;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        emit_q |=> !emit_q);

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        emit_q |-> ((code_q >= 4'd1 && code_q <= 4'd7) || (code_q >= 4'd9 && code_q <= 4'd12)));

    // R7
    wr_ras_chk: assert property (@(posedge clk) disable iff (rst)
        (|wr_q) |-> !$past(cur.ras));

    // R8
    drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_q & wr_q) == '0);

endmodule

// File: rtl/strobe_mode_decoder.sv
`timescale 1ns/1ps
module strobe_mode_decoder
    import strobe_dec_pkg::*;
#(
    parameter int AW       = 9,
    parameter int RW       = 9,
    parameter int SELF_CYC = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          ucas_n,
    input  logic          lcas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic          cyc_pulse,
    output logic [3:0]    cyc_mode,
    output logic [1:0]    byte_wr,
    output logic [1:0]    byte_drive,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q,
    output logic [RW-1:0] ref_row,
    output logic          mix_err
);
    pins_t  pins;
    edges_t ev;
    logic   cbr_step;

    always_comb begin
        pins.ras = ras_n;
        pins.cas = {ucas_n, lcas_n};
        pins.we  = we_n;
        pins.oe  = oe_n;
    end

    strobe_sampler u_sampler (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n ({ucas_n, lcas_n}),
        .we_n  (we_n),
        .ev    (ev)
    );

    cycle_classifier #(.AW(AW), .SELF_CYC(SELF_CYC)) u_class (
        .clk      (clk),
        .rst      (rst),
        .cur      (pins),
        .ev       (ev),
        .addr     (addr),
        .emit_q   (cyc_pulse),
        .code_q   (cyc_mode),
        .wr_q     (byte_wr),
        .drv_q    (byte_drive),
        .mix_q    (mix_err),
        .row_q    (row_q),
        .col_q    (col_q),
        .cbr_step (cbr_step)
    );

    refresh_row_ctr #(.RW(RW)) u_refresh (
        .clk  (clk),
        .rst  (rst),
        .step (cbr_step),
        .row  (ref_row)
    );

endmodule

// File: tb/strobe_mode_decoder_tb_top.sv
`timescale 1ns/1ps
module strobe_mode_decoder_tb_top;

    localparam int SELF_CYC = 32;
    localparam int C_READ = 1, C_EARLY = 2, C_LATE = 3, C_RMW = 4;
    localparam int C_ROWREF = 5, C_CBR = 6, C_SELF = 7;

    logic       clk = 1'b0;
    logic       rst;
    logic       ras_n, ucas_n, lcas_n, we_n, oe_n;
    logic [8:0] addr;
    logic       cyc_pulse, mix_err;
    logic [3:0] cyc_mode;
    logic [1:0] byte_wr, byte_drive;
    logic [8:0] row_q, col_q, ref_row;

    always #2.5 clk = ~clk;

    strobe_mode_decoder #(.AW(9), .RW(9), .SELF_CYC(SELF_CYC)) dut_i (
        .clk(clk), .rst(rst), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .cyc_pulse(cyc_pulse),
        .cyc_mode(cyc_mode), .byte_wr(byte_wr), .byte_drive(byte_drive),
        .row_q(row_q), .col_q(col_q), .ref_row(ref_row), .mix_err(mix_err)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    int         exp_ref = 0;
    int         np = 0;
    logic [3:0] mlog [8];
    logic [1:0] wr_acc, drv_acc;
    logic       mix_acc;

    always @(negedge clk) begin
        if (!rst) begin
            if (cyc_pulse) begin
                if (np < 8) mlog[np] = cyc_mode;
                np = np + 1;
            end
            wr_acc  = wr_acc | byte_wr;
            drv_acc = drv_acc | byte_drive;
            mix_acc = mix_acc | mix_err;
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_mon();
        @(posedge clk);
        np = 0; wr_acc = 2'b00; drv_acc = 2'b00; mix_acc = 1'b0;
        @(negedge clk);
    endtask

    function automatic int exp_wr(input int kind, input logic [1:0] mask);
        return (kind == C_READ) ? 0 : int'(mask);
    endfunction

    function automatic int exp_drv(input int kind, input logic [1:0] mask);
        return (kind == C_READ || kind == C_RMW) ? int'(mask) : 0;
    endfunction

    task automatic do_access(input int kind, input int npg, input logic [1:0] mask);
        logic [8:0] row, col;
        row = 9'($urandom);
        col = 9'd0;
        clear_mon();
        addr = row; ras_n = 1'b0; step(); step();
        for (int p = 0; p < npg; p++) begin
            col = 9'($urandom);
            addr = col;
            if (kind == C_EARLY) we_n = 1'b0;
            step();
            ucas_n = ~mask[1]; lcas_n = ~mask[0];
            step(); step();
            case (kind)
                C_READ:  begin oe_n = 1'b0; step(); step(); step(); oe_n = 1'b1; step(); end
                C_EARLY: step();
                C_LATE:  begin we_n = 1'b0; step(); we_n = 1'b1; step(); end
                default: begin
                    oe_n = 1'b0; step(); step(); oe_n = 1'b1; step();
                    we_n = 1'b0; step(); we_n = 1'b1; step();
                end
            endcase
            ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1;
            step();
            chk_eq("R2 pulse one clock after strobes close", int'(cyc_pulse), 1);
            chk_eq("R6/R9 code at close", int'(cyc_mode), (p == 0) ? kind : kind + 8);
            step();
        end
        ras_n = 1'b1; step(); step();
        chk_eq("R2 pulse count per row cycle", np, npg);
        if (np > 0) chk_eq("R6 first access code", int'(mlog[0]), kind);
        if (np > 1) chk_eq("R9 page access code", int'(mlog[np > 8 ? 7 : np - 1]), kind + 8);
        chk_eq("R7 lanes written", int'(wr_acc), exp_wr(kind, mask));
        chk_eq("R8 lanes driven", int'(drv_acc), exp_drv(kind, mask));
        chk_eq("R10 no mixing flag on legal cycle", int'(mix_acc), 0);
        chk_eq("R5 row latched at row strobe fall", int'(row_q), int'(row));
        chk_eq("R9 column latched at last opening", int'(col_q), int'(col));
        chk_eq("R5 refresh row untouched by access", int'(ref_row), exp_ref);
    endtask

    task automatic do_row_ref();
        logic [8:0] row;
        row = 9'($urandom);
        clear_mon();
        addr = row; ras_n = 1'b0; step(); step(); step();
        ras_n = 1'b1; step();
        chk_eq("R5 row-only refresh pulse", int'(cyc_pulse), 1);
        chk_eq("R5 row-only refresh code", int'(cyc_mode), C_ROWREF);
        step();
        chk_eq("R5 row latched", int'(row_q), int'(row));
        chk_eq("R5 refresh row unchanged", int'(ref_row), exp_ref);
        chk_eq("R2 single pulse", np, 1);
    endtask

    task automatic do_cbr(input int nlow, input logic [1:0] mask);
        int exp_code;
        exp_code = (nlow > SELF_CYC) ? C_SELF : C_CBR;
        clear_mon();
        we_n = 1'($urandom_range(0, 1));
        ucas_n = ~mask[1]; lcas_n = ~mask[0];
        step();
        ras_n = 1'b0;
        repeat (nlow) step();
        ras_n = 1'b1;
        step();
        if (exp_code == C_CBR) exp_ref = (exp_ref + 1) % 512;
        chk_eq("R3/R4 refresh pulse after row strobe rise", int'(cyc_pulse), 1);
        chk_eq(exp_code == C_CBR ? "R3 strobe-first refresh code" : "R4 self refresh code",
               int'(cyc_mode), exp_code);
        chk_eq("R3/R4/R11 refresh row value", int'(ref_row), exp_ref);
        ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1;
        step(); step();
        chk_eq("R3 no byte write during refresh", int'(wr_acc), 0);
        chk_eq("R3 single pulse", np, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; ras_n = 1'b1; ucas_n = 1'b1; lcas_n = 1'b1;
        we_n = 1'b1; oe_n = 1'b1; addr = '0;
        wr_acc = 2'b00; drv_acc = 2'b00; mix_acc = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: state after reset
        chk_eq("R1 cyc_pulse after reset", int'(cyc_pulse), 0);
        chk_eq("R1 cyc_mode after reset", int'(cyc_mode), 0);
        chk_eq("R1 byte_wr after reset", int'(byte_wr), 0);
        chk_eq("R1 byte_drive after reset", int'(byte_drive), 0);
        chk_eq("R1 mix_err after reset", int'(mix_err), 0);
        chk_eq("R1 row_q after reset", int'(row_q), 0);
        chk_eq("R1 col_q after reset", int'(col_q), 0);
        chk_eq("R1 ref_row after reset", int'(ref_row), 0);

        // directed: each access kind, both single lanes and both lanes
        do_access(C_READ, 1, 2'b11);
        do_access(C_EARLY, 1, 2'b01);
        do_access(C_LATE, 1, 2'b10);
        do_access(C_RMW, 1, 2'b11);
        do_access(C_READ, 3, 2'b10);
        do_access(C_EARLY, 2, 2'b11);
        do_row_ref();
        do_cbr(3, 2'b01);
        do_cbr(3, 2'b10);

        // R2: row strobe rising while a column access is still open closes it
        clear_mon();
        ras_n = 1'b0; step(); step();
        lcas_n = 1'b0; step();
        oe_n = 1'b0; step();
        ras_n = 1'b1; step();
        chk_eq("R2 close by row strobe pulse", int'(cyc_pulse), 1);
        chk_eq("R2 close by row strobe code", int'(cyc_mode), C_READ);
        oe_n = 1'b1; lcas_n = 1'b1; step(); step();
        chk_eq("R2 one pulse for row-closed access", np, 1);

        // R10: upper early write, lower falls after write enable returned high
        clear_mon();
        ras_n = 1'b0; step(); step();
        we_n = 1'b0; ucas_n = 1'b0; step();
        we_n = 1'b1; step();
        lcas_n = 1'b0; step();
        chk_eq("R10 mixing flag, early then read lane", int'(mix_err), 1);
        ucas_n = 1'b1; lcas_n = 1'b1; step();
        chk_eq("R10 access still decoded as early write", int'(cyc_mode), C_EARLY);
        ras_n = 1'b1; step(); step();
        chk_eq("R7 only upper lane written", int'(wr_acc), 2);

        // R10: lower delayed write, then upper falls after the write
        clear_mon();
        ras_n = 1'b0; step(); step();
        lcas_n = 1'b0; step();
        we_n = 1'b0; step();
        we_n = 1'b1; step();
        ucas_n = 1'b0; step();
        chk_eq("R10 mixing flag, strobe after delayed write", int'(mix_err), 1);
        ucas_n = 1'b1; lcas_n = 1'b1; step();
        chk_eq("R6 delayed write code", int'(cyc_mode), C_LATE);
        ras_n = 1'b1; step(); step();
        chk_eq("R7 only lower lane written", int'(wr_acc), 1);

        // R4: self-refresh threshold boundary
        do_cbr(SELF_CYC, 2'b11);
        do_cbr(SELF_CYC + 1, 2'b11);

        // seeded random mix of all cycle kinds
        for (int it = 0; it < 150; it++) begin
            int kind;
            logic [1:0] mask;
            kind = $urandom_range(0, 5);
            mask = 2'($urandom_range(1, 3));
            if (kind >= 1 && kind <= 4)
                do_access(kind, $urandom_range(1, 3), mask);
            else if (kind == 0)
                do_row_ref();
            else if ($urandom_range(0, 7) == 0)
                do_cbr(SELF_CYC + $urandom_range(1, 4), mask);
            else
                do_cbr($urandom_range(2, 8), mask);
        end

        // R11: drive the refresh counter to 511 and across the wrap
        while (exp_ref != 511) do_cbr(2, 2'b11);
        chk_eq("R11 refresh row at top", int'(ref_row), 511);
        do_cbr(2, 2'b01);
        chk_eq("R11 refresh row wraps to zero", int'(ref_row), 0);

        summary();
        $finish;
    end

endmodule